// File: doc/BRIEF.md
# Comparison-Free Counting Sorter

This block puts a set of `SET_N` unsigned keys, each `KEY_W` bits wide, into ascending order without ever comparing one key with another. A start strobe opens a new set. The block then takes in the keys one at a time through a valid/data pair. Each key is decoded one-hot onto a row of per-value cells. Every cell holds a presence flag and an occurrence counter, so repeated keys are kept rather than merged.

Once the last key of the set has been taken in, the block switches to its emit phase. In every cycle a priority picker selects the lowest value whose presence flag is still set. The block puts that value on the output and decrements the counter for that value. When the counter drops to zero, the presence flag clears, and the picker moves on to the next higher value. The done flag rises together with the last output element. A new start may arrive in that same cycle, so sets can follow each other with no gap. All storage is plain registers.

Top module: `cfs_sorter`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `out_valid` and `done` are low.
- R2: A `start` pulse seen while the block is idle clears every presence flag and counter. The block then absorbs exactly `SET_N` keys, one for each cycle in which `in_valid` is high. A cycle with `in_valid` low pauses absorption without losing any key.
- R3: `in_valid` and `in_data` are ignored outside the absorb phase, both while idle and during the emit phase. Such keys never appear in any output set.
- R4: The emitted keys of a set come out in non-decreasing unsigned order. A key that appeared c times in the input is emitted exactly c times, including the extreme keys 0 and 2^KEY_W-1.
- R5: `out_valid` is high for exactly `SET_N` cycles per set, and these cycles are consecutive.
- R6: `done` is high for one cycle, and only in the cycle that carries the final `out_valid` of a set.
- R7: When the keys follow the start edge back to back, `done` is seen exactly 2·`SET_N` clock edges after the edge that sampled `start`. In every case the latency is at least 2·`SET_N`. Each idle cycle of `in_valid` during absorption adds exactly one cycle.
- R8: A `start` pulse that arrives while a set is being absorbed or emitted has no effect on that set.
- R9: A `start` pulse in the cycle where `done` is high is accepted. The next set is then sorted correctly, with the same latency as a set started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that opens a new set when the block is idle |
| in_valid | input | 1 | Marks `in_data` as a key of the set being absorbed |
| in_data | input | KEY_W | Unsigned key |
| out_valid | output | 1 | Registered; marks `out_data` as the next sorted key |
| out_data | output | KEY_W | Registered sorted key |
| done | output | 1 | Registered; high together with the last key of a set |

## Verification
The delicate overlap is the end of one set meeting the start of the next. In the cycle where `done` and the final key are on the outputs, the control has already returned to idle. A `start` sampled at that edge must clear the value cells, which were just emptied, and begin absorbing without disturbing the key being delivered. The bench causes this by driving `start` at the very negative edge where it first sees `done`. It judges the outcome by comparing the following set's output against a bench-side sort and by checking that set's latency to the exact cycle. A second overlap is also exercised: during emission, keys and start pulses are applied on every cycle, and the bench confirms that they leave the ordered stream and its timing untouched.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_READ = 2'd2
  } cfs_state_e;
endpackage

// File: rtl/cfs_value_bank.sv
// One cell per possible key value: a presence flag plus an occurrence counter.
module cfs_value_bank #(
  parameter int KEY_W = 4,
  parameter int SET_N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  inc_en,
  input  logic [KEY_W-1:0]      inc_key,
  input  logic                  dec_en,
  input  logic [KEY_W-1:0]      dec_key,
  output logic [(1<<KEY_W)-1:0] present
);
  localparam int VALS  = 1 << KEY_W;
  localparam int CNT_W = $clog2(SET_N + 1);

  for (genvar g = 0; g < VALS; g++) begin : g_cell
    logic [CNT_W-1:0] cnt_q;
    logic             hit_inc;
    logic             hit_dec;

    assign hit_inc = inc_en && (inc_key == KEY_W'(g));
    assign hit_dec = dec_en && (dec_key == KEY_W'(g));

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q      <= '0;
        present[g] <= 1'b0;
      end else if (hit_inc) begin
        cnt_q      <= cnt_q + CNT_W'(1);
        present[g] <= 1'b1;
      end else if (hit_dec) begin
        cnt_q      <= cnt_q - CNT_W'(1);
        present[g] <= (cnt_q != CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/cfs_lowest_pick.sv
// Priority encoder: index of the lowest set request bit.
module cfs_lowest_pick #(
  parameter int WIDTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [WIDTH-1:0] req,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cfs_seq.sv
// Phase control: idle -> absorb SET_N keys -> emit SET_N keys -> idle.
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int SET_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  output logic clr,
  output logic load_en,
  output logic emit_en,
  output logic emit_last
);
  localparam int CNT_W = $clog2(SET_N + 1);

  cfs_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_end;

  assign cnt_end   = (cnt_q == CNT_W'(SET_N - 1));
  assign clr       = (state_q == ST_IDLE) && start;
  assign load_en   = (state_q == ST_LOAD) && in_valid;
  assign emit_en   = (state_q == ST_READ);
  assign emit_last = emit_en && cnt_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOAD;
          cnt_q   <= '0;
        end
        ST_LOAD: if (in_valid) begin
          if (cnt_end) begin
            state_q <= ST_READ;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_READ: begin
          if (cnt_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfs_sorter.sv
module cfs_sorter #(
  parameter int KEY_W = 4,
  parameter int SET_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_data,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_data,
  output logic             done
);
  localparam int VALS = 1 << KEY_W;

  logic             clr;
  logic             load_en;
  logic             emit_en;
  logic             emit_last;
  logic [VALS-1:0]  present;
  logic [KEY_W-1:0] pick;

  cfs_seq #(.SET_N(SET_N)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .clr       (clr),
    .load_en   (load_en),
    .emit_en   (emit_en),
    .emit_last (emit_last)
  );

  cfs_value_bank #(.KEY_W(KEY_W), .SET_N(SET_N)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .inc_en  (load_en),
    .inc_key (in_data),
    .dec_en  (emit_en),
    .dec_key (pick),
    .present (present)
  );

  cfs_lowest_pick #(.WIDTH(VALS), .IDX_W(KEY_W)) u_pick (
    .req (present),
    .idx (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit_en;
      done      <= emit_last;
      if (emit_en) out_data <= pick;
    end
  end
endmodule

// File: rtl/cfs_sorter_chk.sv
module cfs_sorter_chk #(
  parameter int KEY_W = 4,
  parameter int SET_N = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_data,
  input logic             done
);
  logic        busy_c;
  logic [31:0] lat_c;
  logic [31:0] vcnt_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      lat_c  <= '0;
      vcnt_c <= '0;
    end else begin
      if (done) begin
        busy_c <= start;
        lat_c  <= '0;
      end else if (start && !busy_c) begin
        busy_c <= 1'b1;
        lat_c  <= '0;
      end else if (busy_c) begin
        lat_c <= lat_c + 32'd1;
      end
      if (done) vcnt_c <= '0;
      else if (out_valid) vcnt_c <= vcnt_c + 32'd1;
    end
  end

  assert_done_with_last_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> out_valid);

  assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !$past(done)) |-> (out_data >= $past(out_data)));

  assert_set_size_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (vcnt_c == 32'(SET_N - 1)));

  assert_min_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_c >= 32'(2 * SET_N)));

  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_c |-> !out_valid);
endmodule

bind cfs_sorter cfs_sorter_chk #(.KEY_W(KEY_W), .SET_N(SET_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .out_valid (out_valid),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/sim_cfs_sorter.sv
`timescale 1ns/1ps
module sim_cfs_sorter;
  localparam int K = 4;
  localparam int N = 8;
  localparam int V = 1 << K;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         in_valid = 1'b0;
  logic [K-1:0] in_data = '0;
  logic         out_valid;
  logic [K-1:0] out_data;
  logic         done;

  cfs_sorter #(.KEY_W(K), .SET_N(N)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int sets_sent = 0;
  int sets_seen = 0;
  bit finished = 0;
  logic [K-1:0] exp_q[$];
  logic [K-1:0] got_q[$];
  int st_q[$];
  int lat_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push_expected(input logic [K-1:0] v [N]);
    logic [K-1:0] s [N];
    for (int i = 0; i < N; i++) s[i] = v[i];
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (s[j] < s[j-1]) begin
          logic [K-1:0] t;
          t = s[j]; s[j] = s[j-1]; s[j-1] = t;
        end
      end
    end
    for (int i = 0; i < N; i++) exp_q.push_back(s[i]);
  endtask

  // Called at a negative edge; start is sampled at the next rising edge.
  task automatic send_set(input logic [K-1:0] v [N], input int gaps);
    push_expected(v);
    sets_sent++;
    st_q.push_back(cyc + 1);
    lat_q.push_back(2 * N + gaps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i > 0 && i <= gaps) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = v[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Returns at the negative edge where done is seen.
  task automatic wait_done(input bit noisy);
    while (!done) begin
      if (noisy) begin
        start    = 1'b1;
        in_valid = 1'b1;
        in_data  = K'($urandom);
      end
      @(negedge clk);
    end
    start    = 1'b0;
    in_valid = 1'b0;
  endtask

  // Output monitor
  always @(negedge clk) begin : mon
    int st;
    int lat;
    logic [K-1:0] e;
    logic [K-1:0] a;
    if (!rst) begin
      if (done && !out_valid) chk(1'b0, "R6 done without out_valid", 0, 1);
      if (out_valid) begin
        got_q.push_back(out_data);
        if (done) begin
          sets_seen++;
          if (st_q.size() == 0) begin
            chk(1'b0, "R2 output set with no accepted start", 1, 0);
          end else begin
            st  = st_q.pop_front();
            lat = lat_q.pop_front();
            chk(got_q.size() == N, "R5 outputs per set", got_q.size(), N);
            for (int i = 0; i < N; i++) begin
              e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
              a = (i < got_q.size()) ? got_q[i] : '0;
              chk(a == e, "R4 sorted key", a, e);
            end
            chk((cyc - st) == lat, "R7 latency", cyc - st, lat);
            chk((cyc - st) <= 3 * N || lat > 3 * N, "R7 upper bound", cyc - st, 3 * N);
          end
          got_q.delete();
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=no_done expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [K-1:0] s [N];
    int dummy;
    dummy = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs low in reset", {out_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs low after reset", {out_valid, done}, 0);

    // R4: all zero keys
    for (int i = 0; i < N; i++) s[i] = '0;
    send_set(s, 0); wait_done(0); @(negedge clk);
    // R4: all maximum keys
    for (int i = 0; i < N; i++) s[i] = K'(V - 1);
    send_set(s, 0); wait_done(0); @(negedge clk);
    // R4: strictly descending input
    for (int i = 0; i < N; i++) s[i] = K'(V - 1 - i);
    send_set(s, 0); wait_done(0); @(negedge clk);
    // R4: extremes mixed with duplicates
    for (int i = 0; i < N; i++) s[i] = (i % 3 == 0) ? K'(V - 1) : ((i % 3 == 1) ? '0 : K'(5));
    send_set(s, 0); wait_done(0); @(negedge clk);

    // R3: keys offered while idle must not appear
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_data = K'(i); @(negedge clk);
    end
    in_valid = 1'b0;
    for (int i = 0; i < N; i++) s[i] = K'(V - 2);
    send_set(s, 0); wait_done(0); @(negedge clk);

    // R3/R8: keys and start pulses hammered during emission
    for (int i = 0; i < N; i++) s[i] = K'($urandom);
    send_set(s, 0); wait_done(1); @(negedge clk);

    // R2/R7: gaps in in_valid during absorption
    for (int i = 0; i < N; i++) s[i] = K'($urandom);
    send_set(s, 3); wait_done(0); @(negedge clk);

    // R9: chained sets, start in the done cycle
    for (int i = 0; i < N; i++) s[i] = K'(i);
    send_set(s, 0); wait_done(0);
    for (int i = 0; i < N; i++) s[i] = K'($urandom);
    send_set(s, 0); wait_done(0);
    for (int i = 0; i < N; i++) s[i] = '0;
    send_set(s, 0); wait_done(0); @(negedge clk);

    // Random sets, every other one chained into the previous done
    for (int r = 0; r < 24; r++) begin
      for (int i = 0; i < N; i++) s[i] = K'($urandom);
      send_set(s, (r % 5 == 4) ? 1 : 0);
      wait_done(r % 3 == 2);
      if (r % 2 == 0) @(negedge clk);
    end
    repeat (4) @(negedge clk);

    chk(sets_seen == sets_sent, "R5 completed sets", sets_seen, sets_sent);
    chk(out_valid == 1'b0 && done == 1'b0, "R6 outputs quiet after last set", {out_valid, done}, 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule